// File: doc/BRIEF.md
# PPS-Anchored Time Base and Frame Arrival Checker

This block keeps the local time of a converter node and uses it in two ways. A sub-second sample counter runs on the converter clock. The same clock drives the logic and is locked to the timing receiver. Every rising edge of the one-pulse-per-second strobe realigns the counter to zero, so time never rests on an endless count of cycles. A seconds register takes its value from the timing receiver through a load port. The loaded value is held pending and applied at the next strobe.

On the sending side, a request captures the full local time (seconds and sub-second count) as a tag for an outgoing frame. On the receiving side, each incoming timestamp is subtracted from the local time. The signed difference is compared against programmable minimum and maximum limits, and frames outside that interval are flagged as early or late. With the default 2^19 counts per second, a link latency budget of under 5 µs is about 2.6 sample periods, so a maximum limit of 2 counts matches it. A sticky flag reports a strobe that arrives off the count boundary, and also a second that ends with no strobe.

Top module: `pps_time_stamp`

## Requirements
- R1: Once time is valid, the sub-second count rises by one each clock. If it reaches 2^SUB_W-1 and no strobe arrives, it wraps to 0 and the seconds value rises by one.
- R2: A rising edge on pps_i passes through two synchronizer flops and an edge detector, and the sub-second count reads 0 after the third rising clock edge that sees pps_i high. Keeping pps_i high longer has no further effect.
- R3: At a strobe, the seconds value takes the value loaded through sec_load_i since the previous strobe, or else rises by one. A load does not change time_sec_o before the strobe.
- R4: time_valid_o is low from reset until the first strobe, then stays high until reset.
- R5: misalign_o is sticky. It is set by a strobe that arrives while time is valid and the count is not 2^SUB_W-1, or by a wrap with no strobe. It is not set by the first strobe, or by strobes spaced exactly 2^SUB_W clocks apart.
- R6: One clock after tx_req_i, tx_tag_vld_o pulses and the tag outputs hold the seconds and sub-second values present in the request cycle.
- R7: One clock after rx_valid_i, chk_valid_o pulses. With delta = ({sec,sub} local in the request cycle − {rx_sec_i,rx_sub_i}) modulo 2^(SEC_W+SUB_W), read as signed: chk_late_o = delta > win_max_i and chk_early_o = delta < win_min_i, both limits signed.
- R8: Seconds at all ones wrap to 0, and the arrival difference is computed correctly across that wrap.
- R9: A frame checked before time is valid gives chk_untimed_o = 1 with chk_late_o and chk_early_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter/logic clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pps_i | input | 1 | Raw one-pulse-per-second strobe |
| sec_load_i | input | 1 | Load a pending seconds value |
| sec_value_i | input | SEC_W | Seconds value to apply at the next strobe |
| rx_valid_i | input | 1 | Received timestamp present |
| rx_sec_i | input | SEC_W | Received seconds |
| rx_sub_i | input | SUB_W | Received sub-second count |
| win_min_i | input | SEC_W+SUB_W | Signed minimum allowed delay |
| win_max_i | input | SEC_W+SUB_W | Signed maximum allowed delay |
| tx_req_i | input | 1 | Capture a transmit tag |
| time_sec_o | output | SEC_W | Local seconds |
| time_sub_o | output | SUB_W | Local sub-second count |
| time_valid_o | output | 1 | Time anchored by a strobe |
| tx_tag_sec_o | output | SEC_W | Tagged seconds |
| tx_tag_sub_o | output | SUB_W | Tagged sub-second count |
| tx_tag_vld_o | output | 1 | Tag pulse |
| chk_valid_o | output | 1 | Arrival check result pulse |
| chk_late_o | output | 1 | Frame older than allowed |
| chk_early_o | output | 1 | Frame newer than allowed |
| chk_untimed_o | output | 1 | Frame checked before time valid |
| misalign_o | output | 1 | Sticky strobe misalignment |

## Verification
The hardest case to reach from the ports is an arrival difference that crosses a seconds wrap from all ones to zero. The bench gets there by loading the seconds value to one below all ones and sending aligned strobes until the count rolls over to 0. Right after that rollover, it sends timestamps from the previous second. The bench also places strobes exactly one second apart, three clocks early, or leaves them out. These cases test both the aligned path and each misalignment path against the fixed latency through the synchronizer.

// File: rtl/pps_time_pkg.sv
package pps_time_pkg;
  localparam int unsigned SYNC_STAGES_DEF = 2;
  typedef enum logic [1:0] {WIN_OK = 2'd0, WIN_EARLY = 2'd1, WIN_LATE = 2'd2} win_res_e;
endpackage

// File: rtl/pps_edge_sync.sv
module pps_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pps_i,
  output logic rise_o
);
  logic [STAGES:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-1:0], pps_i};
  end

  assign rise_o = sr_q[STAGES-1] & ~sr_q[STAGES];
endmodule

// File: rtl/pps_time_base.sv
module pps_time_base #(
  parameter int unsigned SUB_W = 19,
  parameter int unsigned SEC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             load_i,
  input  logic [SEC_W-1:0] load_sec_i,
  output logic [SEC_W-1:0] sec_o,
  output logic [SUB_W-1:0] sub_o,
  output logic             valid_o,
  output logic             misalign_o
);
  localparam logic [SUB_W-1:0] SUB_MAX = {SUB_W{1'b1}};

  logic [SEC_W-1:0] pend_q;
  logic             pend_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_o      <= '0;
      sub_o      <= '0;
      valid_o    <= 1'b0;
      misalign_o <= 1'b0;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
    end else if (rise_i) begin
      sub_o      <= '0;
      valid_o    <= 1'b1;
      pend_vld_q <= 1'b0;
      if (load_i)          sec_o <= load_sec_i;
      else if (pend_vld_q) sec_o <= pend_q;
      else                 sec_o <= sec_o + 1'b1;
      if (valid_o && sub_o != SUB_MAX) misalign_o <= 1'b1;
    end else begin
      sub_o <= sub_o + 1'b1;
      // flywheel: a second ended without a strobe
      if (valid_o && sub_o == SUB_MAX) begin
        sec_o      <= sec_o + 1'b1;
        misalign_o <= 1'b1;
      end
      if (load_i) begin
        pend_q     <= load_sec_i;
        pend_vld_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/arrival_check.sv
module arrival_check
  import pps_time_pkg::*;
#(
  parameter int unsigned TW = 51
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          time_ok_i,
  input  logic [TW-1:0] local_i,
  input  logic [TW-1:0] rx_i,
  input  logic [TW-1:0] win_min_i,
  input  logic [TW-1:0] win_max_i,
  output logic          chk_vld_o,
  output logic          late_o,
  output logic          early_o,
  output logic          untimed_o
);
  logic [TW-1:0] delta;
  win_res_e      res;

  // modular difference handles seconds rollover
  assign delta = local_i - rx_i;

  always_comb begin
    if ($signed(delta) > $signed(win_max_i))      res = WIN_LATE;
    else if ($signed(delta) < $signed(win_min_i)) res = WIN_EARLY;
    else                                          res = WIN_OK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_vld_o <= 1'b0;
      late_o    <= 1'b0;
      early_o   <= 1'b0;
      untimed_o <= 1'b0;
    end else begin
      chk_vld_o <= valid_i;
      late_o    <= valid_i && time_ok_i && res == WIN_LATE;
      early_o   <= valid_i && time_ok_i && res == WIN_EARLY;
      untimed_o <= valid_i && !time_ok_i;
    end
  end
endmodule

// File: rtl/pps_time_stamp.sv
module pps_time_stamp #(
  parameter int unsigned SUB_W       = 19,
  parameter int unsigned SEC_W       = 32,
  parameter int unsigned SYNC_STAGES = pps_time_pkg::SYNC_STAGES_DEF,
  localparam int unsigned TW         = SEC_W + SUB_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pps_i,
  input  logic             sec_load_i,
  input  logic [SEC_W-1:0] sec_value_i,
  input  logic             rx_valid_i,
  input  logic [SEC_W-1:0] rx_sec_i,
  input  logic [SUB_W-1:0] rx_sub_i,
  input  logic [TW-1:0]    win_min_i,
  input  logic [TW-1:0]    win_max_i,
  input  logic             tx_req_i,
  output logic [SEC_W-1:0] time_sec_o,
  output logic [SUB_W-1:0] time_sub_o,
  output logic             time_valid_o,
  output logic [SEC_W-1:0] tx_tag_sec_o,
  output logic [SUB_W-1:0] tx_tag_sub_o,
  output logic             tx_tag_vld_o,
  output logic             chk_valid_o,
  output logic             chk_late_o,
  output logic             chk_early_o,
  output logic             chk_untimed_o,
  output logic             misalign_o
);
  logic pps_rise;

  pps_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pps_i  (pps_i),
    .rise_o (pps_rise)
  );

  pps_time_base #(.SUB_W(SUB_W), .SEC_W(SEC_W)) u_base (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (pps_rise),
    .load_i     (sec_load_i),
    .load_sec_i (sec_value_i),
    .sec_o      (time_sec_o),
    .sub_o      (time_sub_o),
    .valid_o    (time_valid_o),
    .misalign_o (misalign_o)
  );

  arrival_check #(.TW(TW)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (rx_valid_i),
    .time_ok_i (time_valid_o),
    .local_i   ({time_sec_o, time_sub_o}),
    .rx_i      ({rx_sec_i, rx_sub_i}),
    .win_min_i (win_min_i),
    .win_max_i (win_max_i),
    .chk_vld_o (chk_valid_o),
    .late_o    (chk_late_o),
    .early_o   (chk_early_o),
    .untimed_o (chk_untimed_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_tag_sec_o <= '0;
      tx_tag_sub_o <= '0;
      tx_tag_vld_o <= 1'b0;
    end else begin
      tx_tag_vld_o <= tx_req_i;
      if (tx_req_i) begin
        tx_tag_sec_o <= time_sec_o;
        tx_tag_sub_o <= time_sub_o;
      end
    end
  end
endmodule

// File: rtl/pps_time_stamp_chk.sv
module pps_time_stamp_chk #(
  parameter int unsigned SUB_W = 19,
  parameter int unsigned SEC_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pps_rise,
  input logic             rx_valid_i,
  input logic             tx_req_i,
  input logic [SEC_W-1:0] time_sec_o,
  input logic [SUB_W-1:0] time_sub_o,
  input logic             time_valid_o,
  input logic [SEC_W-1:0] tx_tag_sec_o,
  input logic [SUB_W-1:0] tx_tag_sub_o,
  input logic             chk_valid_o,
  input logic             chk_late_o,
  input logic             chk_early_o,
  input logic             chk_untimed_o,
  input logic             misalign_o
);
  localparam logic [SUB_W-1:0] SUB_MAX = {SUB_W{1'b1}};

  AST_SUB_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_valid_o && !pps_rise |=> time_sub_o == SUB_W'($past(time_sub_o) + 1'b1)); // R1
  AST_PPS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pps_rise |=> time_sub_o == '0 && time_valid_o); // R2
  AST_SEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_valid_o && !pps_rise && time_sub_o != SUB_MAX |=> $stable(time_sec_o)); // R3
  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_valid_o |=> time_valid_o); // R4
  AST_MIS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |=> misalign_o); // R5
  AST_TAG_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_i |=> {tx_tag_sec_o, tx_tag_sub_o} == $past({time_sec_o, time_sub_o})); // R6
  AST_CHK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> chk_valid_o); // R7
  AST_CHK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> !chk_valid_o && !chk_late_o && !chk_early_o); // R7
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(chk_late_o && chk_early_o)); // R7
  AST_UNTIMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && !time_valid_o |=> chk_untimed_o && !chk_late_o && !chk_early_o); // R9
endmodule

bind pps_time_stamp pps_time_stamp_chk #(.SUB_W(SUB_W), .SEC_W(SEC_W)) u_ast (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pps_rise      (pps_rise),
  .rx_valid_i    (rx_valid_i),
  .tx_req_i      (tx_req_i),
  .time_sec_o    (time_sec_o),
  .time_sub_o    (time_sub_o),
  .time_valid_o  (time_valid_o),
  .tx_tag_sec_o  (tx_tag_sec_o),
  .tx_tag_sub_o  (tx_tag_sub_o),
  .chk_valid_o   (chk_valid_o),
  .chk_late_o    (chk_late_o),
  .chk_early_o   (chk_early_o),
  .chk_untimed_o (chk_untimed_o),
  .misalign_o    (misalign_o)
);

// File: tb/pps_time_stamp_bench.sv
module pps_time_stamp_bench;
  localparam int SUB_W = 4;
  localparam int SEC_W = 8;
  localparam int TW    = SUB_W + SEC_W;
  localparam int CNT   = 1 << SUB_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pps = 1'b0;
  logic             sec_load = 1'b0;
  logic [SEC_W-1:0] sec_value = '0;
  logic             rx_valid = 1'b0;
  logic [SEC_W-1:0] rx_sec = '0;
  logic [SUB_W-1:0] rx_sub = '0;
  logic [TW-1:0]    win_min = '0;
  logic [TW-1:0]    win_max = '0;
  logic             tx_req = 1'b0;
  logic [SEC_W-1:0] time_sec, tag_sec;
  logic [SUB_W-1:0] time_sub, tag_sub;
  logic time_valid, tag_vld, chk_vld, late, early, untimed, misalign;

  int n_chk = 0;
  int n_fail = 0;

  pps_time_stamp #(.SUB_W(SUB_W), .SEC_W(SEC_W)) u_pps_time_stamp (
    .clk_i(clk), .rst_ni(rst_n), .pps_i(pps), .sec_load_i(sec_load),
    .sec_value_i(sec_value), .rx_valid_i(rx_valid), .rx_sec_i(rx_sec),
    .rx_sub_i(rx_sub), .win_min_i(win_min), .win_max_i(win_max),
    .tx_req_i(tx_req), .time_sec_o(time_sec), .time_sub_o(time_sub),
    .time_valid_o(time_valid), .tx_tag_sec_o(tag_sec), .tx_tag_sub_o(tag_sub),
    .tx_tag_vld_o(tag_vld), .chk_valid_o(chk_vld), .chk_late_o(late),
    .chk_early_o(early), .chk_untimed_o(untimed), .misalign_o(misalign)
  );

  always #4 clk = ~clk;

  task automatic chk_eq(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    pps = 1'b0; sec_load = 1'b0; rx_valid = 1'b0; tx_req = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  // raise pps, report sub after 3 edges, drop after 4 edges
  task automatic pps_pulse(output int sub3);
    pps = 1'b1;
    cyc(3);
    sub3 = int'(time_sub);
    cyc(1);
    pps = 1'b0;
  endtask

  task automatic rx_probe(string req, int d, int wmin, int wmax);
    logic [TW-1:0] rx_t;
    rx_t = {time_sec, time_sub} - TW'(d);
    win_min = TW'(wmin);
    win_max = TW'(wmax);
    {rx_sec, rx_sub} = rx_t;
    rx_valid = 1'b1;
    cyc(1);
    rx_valid = 1'b0;
    chk_eq(req, "chk_valid", int'(chk_vld), 1);
    chk_eq(req, $sformatf("late d=%0d", d), int'(late), int'(d > wmax));
    chk_eq(req, $sformatf("early d=%0d", d), int'(early), int'(d < wmin));
    chk_eq(req, "untimed", int'(untimed), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int s3;
    logic [TW-1:0] rec;
    do_reset();
    // R4 reset state
    chk_eq("R4", "time_valid at reset", int'(time_valid), 0);
    chk_eq("R5", "misalign at reset", int'(misalign), 0);
    chk_eq("R7", "chk_valid idle", int'(chk_vld), 0);

    // R9 frame before any strobe
    rx_valid = 1'b1; cyc(1); rx_valid = 1'b0;
    chk_eq("R9", "untimed", int'(untimed), 1);
    chk_eq("R9", "late", int'(late), 0);
    chk_eq("R9", "early", int'(early), 0);

    // R3 load is pending only
    sec_value = 8'd10; sec_load = 1'b1; cyc(1); sec_load = 1'b0;
    cyc(2);
    chk_eq("R3", "sec before strobe", int'(time_sec), 0);

    pps_pulse(s3);
    chk_eq("R2", "sub after 3 edges", s3, 0);
    chk_eq("R3", "loaded sec", int'(time_sec), 10);
    chk_eq("R4", "time_valid", int'(time_valid), 1);
    chk_eq("R2", "held level no re-zero", int'(time_sub), 1);
    chk_eq("R5", "first strobe no misalign", int'(misalign), 0);

    // R1 full sub sweep, then aligned strobe
    for (int j = 1; j <= CNT - 4; j++) begin
      cyc(1);
      chk_eq("R1", "sub step", int'(time_sub), (1 + j) % CNT);
    end
    pps_pulse(s3);
    chk_eq("R2", "aligned zero", s3, 0);
    chk_eq("R3", "sec increment", int'(time_sec), 11);
    chk_eq("R5", "aligned no misalign", int'(misalign), 0);

    // R8 load 254, aligned strobes to rollover
    sec_value = 8'd254; sec_load = 1'b1; cyc(1); sec_load = 1'b0;
    cyc(CNT - 5);
    pps_pulse(s3);
    chk_eq("R3", "loaded 254", int'(time_sec), 254);
    cyc(CNT - 4);
    pps_pulse(s3);
    chk_eq("R8", "sec all ones", int'(time_sec), 255);
    cyc(CNT - 4);
    pps_pulse(s3);
    chk_eq("R8", "sec wraps", int'(time_sec), 0);
    chk_eq("R5", "still aligned", int'(misalign), 0);
    rx_probe("R8", 2, 0, 2);
    rx_probe("R8", 4, 0, 2);
    rx_probe("R8", -1, 0, 2);

    // R7 window sweeps
    for (int d = -4; d <= 5; d++) rx_probe("R7", d, 0, 2);
    for (int d = -3; d <= 3; d++) rx_probe("R7", d, 1, 1);
    for (int d = -4; d <= 2; d++) rx_probe("R7", d, -2, 0);

    // R6 transmit tag
    rec = {time_sec, time_sub};
    tx_req = 1'b1; cyc(1); tx_req = 1'b0;
    chk_eq("R6", "tag vld", int'(tag_vld), 1);
    chk_eq("R6", "tag value", int'({tag_sec, tag_sub}), int'(rec));
    cyc(1);
    chk_eq("R6", "tag vld pulse", int'(tag_vld), 0);

    // R1/R5 flywheel wrap without strobe
    do_reset();
    pps_pulse(s3);
    chk_eq("R3", "increment from reset", int'(time_sec), 1);
    cyc(CNT - 1);
    chk_eq("R1", "wrap sub", int'(time_sub), 0);
    chk_eq("R1", "wrap sec", int'(time_sec), 2);
    chk_eq("R5", "missing strobe", int'(misalign), 1);

    // R5 early strobe
    do_reset();
    pps_pulse(s3);
    cyc(CNT - 7);
    pps_pulse(s3);
    chk_eq("R2", "early strobe zero", s3, 0);
    chk_eq("R5", "early strobe misalign", int'(misalign), 1);
    chk_eq("R3", "early strobe sec", int'(time_sec), 2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule